// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits beside an I2C master and returns a serial memory slave to a known idle state after power-up or after a command was cut off part way. On a trigger it runs one of three recovery patterns on SCL and SDA, then pulses a done flag. After that flag the normal transaction logic may take over the bus. The pins are open-drain: each output asks for its line to be pulled low, and a released line floats high through the bus pull-up. The block samples the bus through a synchronizer.

The pattern is chosen by a two-bit mode input:
- 0 (flush) sends fourteen dummy clocks and then two start conditions.
- 1 (framed) sends a start, nine dummy clocks and a second start.
- 2 (train) sends nine start conditions back to back.
- 3 is reserved, and a trigger with it does nothing.

Before any pattern runs, the block releases both lines and waits until the bus reads idle. A slave that is holding SDA low is clocked free by single SCL pulses. SDA is never driven during dummy clocks, because a slave may be holding SDA low there for an acknowledge or a zero data bit.

The controller has the following states and transitions. Every state other than IDLE and DONE lasts one half SCL period (SCL_DIV/2 system clocks).
- IDLE goes to PREP on a trigger with a valid mode.
- PREP goes to PREP_LO if SCL is high and SDA is low. It goes to DUM_LO when the bus is idle and dummy clocks come first. Otherwise it goes to START.
- PREP_LO returns to PREP.
- DUM_LO goes to DUM_HI.
- DUM_HI goes back to DUM_LO while dummy clocks remain, and to START after the last one.
- START (SDA falls while SCL is high) goes to REP_LO.
- REP_LO goes to TAIL when no starts remain. In framed mode with dummy clocks still pending it goes to DUM_LO. Otherwise it goes to REP_REL.
- REP_REL goes to REP_HI, and REP_HI goes to START.
- TAIL goes to DONE, and DONE returns to IDLE after one cycle.

Top module: `bus_recovery_seq`

## Requirements
- R1: While reset is applied, and whenever the block is idle, it drives neither SCL nor SDA low, and busy and done are 0.
- R2: Mode 0 gives exactly 14 SCL rising edges before the first start condition and two start conditions in total. Counting the final release, the bus sees 16 SCL rising edges.
- R3: Mode 1 gives a start condition, then exactly 9 SCL rising edges, then a second start condition. Counting the final release, the bus sees 10 SCL rising edges.
- R4: Mode 2 gives nine start conditions. Between starts, SCL goes low and SDA is raised while SCL is low; only then does SCL rise. Counting the final release, the bus sees 9 SCL rising edges.
- R5: At every SCL rising edge the block releases SDA. A slave holding SDA low during dummy clocks is therefore never opposed.
- R6: The block never changes both of its line drives in the same cycle. It never releases SDA while SCL is released, so it never produces a stop condition.
- R7: In PREP, if SCL reads high and SDA reads low at the end of a half period, the block issues one SCL low/high pulse and checks again. The pattern starts only once both lines read high.
- R8: Each bus phase lasts SCL_DIV/2 clocks. Take the clock edge that samples the trigger as edge 1. With an idle bus, done is seen after edge 36·SCL_DIV/2+1 for modes 0 and 2, and after edge 24·SCL_DIV/2+1 for mode 1.
- R9: done is high for exactly one cycle. The sequence ends with SCL low, then SDA released, then SCL released, so after done both lines read high.
- R10: A trigger is ignored while busy, and a trigger with mode 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Starts a recovery sequence when idle |
| mode | input | 2 | Pattern select: 0 flush, 1 framed, 2 train, 3 reserved |
| scl_in | input | 1 | Level read from the SCL line |
| sda_in | input | 1 | Level read from the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the sequence has finished |

## Verification
The properties assume that trig and mode are synchronous to clk. They also assume that the half period is longer than the synchronizer delay, so a PREP decision sees the bus level left by the previous phase. The bus levels themselves are not assumed to follow any protocol.

The stimulus models the bus as a wired AND of the block's drives and a slave's SDA pull. The slave pulls SDA only while SCL is low, so it never creates a start or stop of its own. Trigger pulses and mode changes are applied at falling clock edges and last one cycle.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREP,
        ST_PREP_LO,
        ST_DUM_LO,
        ST_DUM_HI,
        ST_START,
        ST_REP_LO,
        ST_REP_REL,
        ST_REP_HI,
        ST_TAIL,
        ST_DONE
    } rcv_state_t;

    typedef enum logic [1:0] {
        MODE_FLUSH  = 2'd0,
        MODE_FRAMED = 2'd1,
        MODE_TRAIN  = 2'd2,
        MODE_RSVD   = 2'd3
    } rcv_mode_t;

endpackage

// File: rtl/rcv_sync.sv
module rcv_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Idle bus level is high, so every stage resets to ones.
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rcv_half_timer.sv
module rcv_half_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= TW'(HALF - 1);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/rcv_plan.sv
module rcv_plan
    import rcv_pkg::*;
#(
    parameter int NDUM_LONG    = 14,
    parameter int NDUM_SHORT   = 9,
    parameter int NSTART_TRAIN = 9,
    parameter int CW           = 4
) (
    input  logic [1:0]    mode,
    output logic          valid,
    output logic [CW-1:0] dummies,
    output logic [CW-1:0] starts,
    output logic          framed
);
    always_comb begin
        valid   = 1'b1;
        dummies = '0;
        starts  = CW'(2);
        framed  = 1'b0;
        unique case (mode)
            MODE_FLUSH:  dummies = CW'(NDUM_LONG);
            MODE_FRAMED: begin
                dummies = CW'(NDUM_SHORT);
                framed  = 1'b1;
            end
            MODE_TRAIN:  starts = CW'(NSTART_TRAIN);
            default:     valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
    import rcv_pkg::*;
#(
    parameter int SCL_DIV      = 500,
    parameter int SYNC_STAGES  = 2,
    parameter int NDUM_LONG    = 14,
    parameter int NDUM_SHORT   = 9,
    parameter int NSTART_TRAIN = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [1:0] mode,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_low,
    output logic       sda_low,
    output logic       busy,
    output logic       done
);
    localparam int HALF  = SCL_DIV / 2;
    localparam int MAX_A = (NDUM_LONG > NDUM_SHORT) ? NDUM_LONG : NDUM_SHORT;
    localparam int MAXN  = (MAX_A > NSTART_TRAIN) ? MAX_A : NSTART_TRAIN;
    localparam int CW    = $clog2(MAXN + 1);

    rcv_state_t    state_q, state_d;
    logic [CW-1:0] dum_q, st_q;
    logic          fr_q;
    logic          expire;
    logic [1:0]    bus_s;
    logic          plan_ok, plan_fr;
    logic [CW-1:0] plan_dum, plan_st;

    rcv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(bus_s)
    );

    rcv_half_timer #(.HALF(HALF)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(state_d != state_q), .expire(expire)
    );

    rcv_plan #(
        .NDUM_LONG(NDUM_LONG), .NDUM_SHORT(NDUM_SHORT),
        .NSTART_TRAIN(NSTART_TRAIN), .CW(CW)
    ) u_plan (
        .mode(mode), .valid(plan_ok), .dummies(plan_dum),
        .starts(plan_st), .framed(plan_fr)
    );

    // State register with the two pattern counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dum_q   <= '0;
            st_q    <= '0;
            fr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && trig && plan_ok) begin
                dum_q <= plan_dum;
                st_q  <= plan_st;
                fr_q  <= plan_fr;
            end
            if (state_q == ST_DUM_HI && expire) dum_q <= dum_q - 1'b1;
            if (state_q == ST_START && expire)  st_q  <= st_q - 1'b1;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig && plan_ok) state_d = ST_PREP;
            ST_PREP:    if (expire) begin
                            if (bus_s[1] && bus_s[0])
                                state_d = (dum_q != '0 && !fr_q) ? ST_DUM_LO : ST_START;
                            else if (bus_s[1])
                                state_d = ST_PREP_LO;
                        end
            ST_PREP_LO: if (expire) state_d = ST_PREP;
            ST_DUM_LO:  if (expire) state_d = ST_DUM_HI;
            ST_DUM_HI:  if (expire) state_d = (dum_q == CW'(1)) ? ST_START : ST_DUM_LO;
            ST_START:   if (expire) state_d = ST_REP_LO;
            ST_REP_LO:  if (expire) begin
                            if (st_q == '0)              state_d = ST_TAIL;
                            else if (fr_q && dum_q != '0) state_d = ST_DUM_LO;
                            else                          state_d = ST_REP_REL;
                        end
            ST_REP_REL: if (expire) state_d = ST_REP_HI;
            ST_REP_HI:  if (expire) state_d = ST_START;
            ST_TAIL:    if (expire) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs, decoded from the state alone
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_PREP:    ;
            ST_PREP_LO: scl_low = 1'b1;
            ST_DUM_LO:  scl_low = 1'b1;
            ST_DUM_HI:  ;
            ST_START:   sda_low = 1'b1;
            ST_REP_LO:  begin scl_low = 1'b1; sda_low = 1'b1; end
            ST_REP_REL: scl_low = 1'b1;
            ST_REP_HI:  ;
            ST_TAIL:    scl_low = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig,
    input logic [1:0] mode,
    input logic       scl_low,
    input logic       sda_low,
    input logic       busy,
    input logic       done
);
    // R5
    sda_rel_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_low) |-> !sda_low);

    // R6
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low != $past(scl_low)) |-> (sda_low == $past(sda_low)));

    // R6
    no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low) |-> scl_low);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_low && !sda_low && !done));

    // R10
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(trig) && ($past(mode) != 2'd3)));
endmodule

bind bus_recovery_seq rcv_checker u_rcv_checker (
    .clk(clk), .rst_n(rst_n), .trig(trig), .mode(mode),
    .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done)
);

// File: tb/tb_bus_recovery_seq.sv
module tb_bus_recovery_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       scl_low, sda_low, busy, done;
    logic       slave_sda = 1'b0;
    logic       scl_in, sda_in;

    int n_chk = 0, n_bad = 0;
    int rises = 0, starts = 0, stops = 0, bad_rises = 0;
    int hold_kind = 0;

    // wired-AND bus with pull-ups
    assign scl_in = ~scl_low;
    assign sda_in = ~(sda_low | slave_sda);

    bus_recovery_seq #(.SCL_DIV(8)) dut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .mode(mode),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    always @(posedge scl_in) begin
        rises++;
        if (sda_low === 1'b1) bad_rises++;
    end
    always @(negedge sda_in) if (scl_in === 1'b1) starts++;
    always @(posedge sda_in) if (scl_in === 1'b1) stops++;

    // slave model: changes SDA only while SCL is low
    always @(negedge scl_in) begin
        if (hold_kind == 1) begin
            if (rises == 2) slave_sda = 1'b1;
            if (rises == 5) slave_sda = 1'b0;
        end else if (hold_kind == 2 && rises == 1) begin
            slave_sda = 1'b0;
        end
    end

    // fields: mode[35:34] slave[33:32] cycles[31:16] rises[15:8] starts[7:0]
    localparam int NV = 5;
    localparam logic [35:0] VEC [NV] = '{
        {2'd0, 2'd0, 16'd145, 8'd16, 8'd2},
        {2'd1, 2'd0, 16'd97,  8'd10, 8'd2},
        {2'd2, 2'd0, 16'd145, 8'd9,  8'd9},
        {2'd0, 2'd1, 16'd145, 8'd16, 8'd2},
        {2'd2, 2'd2, 16'd161, 8'd11, 8'd9}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        rises = 0; starts = 0; stops = 0; bad_rises = 0;
    endtask

    // trigger, count edges until done, then check the done pulse and idle bus
    task automatic run(input logic [1:0] m, input int inject, output int cyc);
        @(negedge clk);
        mode = m;
        trig = 1'b1;
        cyc = 0;
        while (cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            trig = (inject != 0 && cyc == inject);
            if (trig) mode = 2'd2;
            if (done) break;
        end
        chk("R8", "done reached", int'(done), 1);
        @(negedge clk);
        chk("R9", "done width", int'(done), 0);
        chk("R9", "busy after", int'(busy), 0);
        chk("R9", "scl after", int'(scl_in), 1);
        chk("R9", "sda after", int'(sda_in), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "scl_low in reset", int'(scl_low), 0);
        chk("R1", "sda_low in reset", int'(sda_low), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] vm;
            string      tag;
            vm = VEC[i][35:34];
            hold_kind = int'(VEC[i][33:32]);
            slave_sda = (hold_kind == 2);
            repeat (2) @(negedge clk);
            clear_mon();
            tag = (vm == 2'd0) ? "R2" : (vm == 2'd1) ? "R3" : "R4";
            run(vm, 0, cyc);
            chk("R8", "cycles to done", cyc, int'(VEC[i][31:16]));
            chk((hold_kind == 2) ? "R7" : tag, "scl rises", rises, int'(VEC[i][15:8]));
            chk(tag, "start count", starts, int'(VEC[i][7:0]));
            chk("R6", "stop count", stops, 0);
            chk("R5", "rises with sda driven", bad_rises, 0);
            hold_kind = 0;
            slave_sda = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R10: reserved mode is ignored
        clear_mon();
        mode = 2'd3;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10", "busy after reserved mode", int'(busy), 0);
        chk("R10", "rises after reserved mode", rises, 0);
        chk("R10", "sda after reserved mode", int'(sda_in), 1);

        // R10: trigger while busy is ignored
        clear_mon();
        run(2'd1, 20, cyc);
        chk("R10", "cycles with retrigger", cyc, 97);
        chk("R10", "starts with retrigger", starts, 2);
        repeat (40) @(negedge clk);
        chk("R10", "no second run", int'(busy), 0);

        // R1: reset in the middle of a sequence releases the bus
        @(negedge clk);
        mode = 2'd0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "scl mid-run reset", int'(scl_in), 1);
        chk("R1", "sda mid-run reset", int'(sda_in), 1);
        chk("R1", "busy mid-run reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule